// File: doc/BRIEF.md
# Marginal Probability Histogram Unit

This block reduces a finished quantum state vector to measurement statistics. Complex amplitudes stream in one per beat, in increasing basis-state index order. The block squares each amplitude into a probability and adds it into a bin. The bin is chosen by the index bits of a chosen set of measured qubits. That set may be any selection of qubits, including a scattered one. Once the beat flagged as last has been absorbed, the block runs a short scan that forms cumulative sums over the bins.

After the scan, the unit answers sample requests. Each request carries a uniform random number. The unit returns the measured outcome that inverse-CDF lookup selects against the finished histogram. It does this with a fixed one-cycle latency. Any bin can be read back at any time through a combinational read port.

The next pass begins with the next accepted amplitude beat. That beat clears the previous histogram.

Top module: `marginal_hist`

## Requirements
- R1: The probability of a beat is re*re + im*im, where `amp_re` and `amp_im` are AW-bit two's complement values.
- R2: A probability below CUTOFF (default 4) adds nothing to its bin. A probability equal to CUTOFF is kept.
- R3: The bin address is formed from the index bits whose `meas_mask` bit is set. The lowest selected qubit goes to bin address bit 0, the next one up to bit 1, and so on. The mask is captured on the first beat of each pass.
- R4: With an all-zero mask there is a single bin, bin 0. It holds the total probability, and every sample returns 0.
- R5: Each bin is 2*AW+8 bits wide (24 by default) and never wraps; it clamps at all ones. With AW=8, sixteen beats of (-128,-128) into one bin give exactly 524288.
- R6: The first beat of a pass clears every bin. Bins at addresses at or above 2^(number of mask bits) read zero.
- R7: `amp_ready` is low while the cumulative scan runs. `samp_ready` is low from reset, and from the last beat of a pass until its scan has finished. A request raised earlier is held and is not served.
- R8: A sample returns the lowest active bin whose cumulative sum exceeds floor(rand*total / 2^RW). `res_valid` is high for exactly the one cycle after the request was accepted.
- R9: If no active bin exceeds the scaled value, for example when the total is zero, the highest active bin is returned.
- R10: A sample accepted in the same cycle as the first beat of a new pass is answered from the previous, finished histogram.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| amp_valid | input | 1 | Amplitude beat present |
| amp_ready | output | 1 | Amplitude beat can be taken |
| amp_index | input | NQ | Basis-state index of the beat |
| amp_re | input | AW | Real part, two's complement |
| amp_im | input | AW | Imaginary part, two's complement |
| amp_last | input | 1 | Marks the final beat of a pass |
| meas_mask | input | NQ | Set bits select the measured qubits |
| samp_valid | input | 1 | Sample request present |
| samp_ready | output | 1 | Sample request can be taken |
| samp_rand | input | RW | Uniform random value of the request |
| res_valid | output | 1 | Sampled outcome valid |
| res_bin | output | NQ | Sampled outcome (bin address) |
| hist_addr | input | NQ | Bin read address |
| hist_data | output | 2*AW+8 | Contents of the addressed bin |

## Verification
Two functions can land in one clock edge: a sample draw is served, and the first beat of a new pass wipes the bins. The bench provokes this by raising `samp_valid` and a beat with index 0 at the same negative edge, while the unit is idle after a scan. It expects a result predicted from the old histogram, and then expects read-back values of the new pass built from its first beat onward. The held-back request, raised before a pass and left high through the whole scan, is judged the same way: any result that appears before the scan ends has no queued prediction and is reported as a failure.

// File: rtl/mhu_pkg.sv
package mhu_pkg;
  typedef enum logic [1:0] {
    ST_GATHER = 2'd0,
    ST_SCAN   = 2'd1,
    ST_DRAW   = 2'd2
  } mhu_state_e;
endpackage

// File: rtl/mhu_prob.sv
module mhu_prob #(
  parameter int AW     = 8,
  parameter int CUTOFF = 4,
  localparam int PW    = 2 * AW
) (
  input  logic [AW-1:0] re,
  input  logic [AW-1:0] im,
  output logic [PW-1:0] prob
);
  logic signed [PW-1:0] sq_re;
  logic signed [PW-1:0] sq_im;
  logic        [PW-1:0] mag;

  always_comb begin
    sq_re = $signed(re) * $signed(re);
    sq_im = $signed(im) * $signed(im);
    mag   = $unsigned(sq_re) + $unsigned(sq_im);
    prob  = (mag < PW'(CUTOFF)) ? '0 : mag;
  end
endmodule

// File: rtl/mhu_bin_pack.sv
module mhu_bin_pack #(
  parameter int NQ = 4
) (
  input  logic [NQ-1:0] idx,
  input  logic [NQ-1:0] mask,
  output logic [NQ-1:0] addr
);
  int pos;

  always_comb begin
    addr = '0;
    pos  = 0;
    for (int q = 0; q < NQ; q++) begin
      if (mask[q]) begin
        addr = addr | (NQ'(idx[q]) << pos);
        pos  = pos + 1;
      end
    end
  end
endmodule

// File: rtl/mhu_draw.sv
module mhu_draw #(
  parameter int NQ    = 4,
  parameter int ACC_W = 24,
  parameter int RW    = 16,
  localparam int NB   = 1 << NQ
) (
  input  logic [ACC_W-1:0] cum [NB],
  input  logic [NQ-1:0]    last_bin,
  input  logic [RW-1:0]    rnd,
  output logic [NQ-1:0]    pick
);
  logic [ACC_W-1:0]    total;
  logic [RW+ACC_W-1:0] scaled;
  logic [ACC_W-1:0]    target;

  always_comb begin
    total  = cum[last_bin];
    scaled = (RW+ACC_W)'(rnd) * (RW+ACC_W)'(total);
    target = scaled[RW +: ACC_W];
    pick   = last_bin;
    for (int b = NB - 1; b >= 0; b--) begin
      if ((NQ'(b) <= last_bin) && (cum[b] > target)) pick = NQ'(b);
    end
  end
endmodule

// File: rtl/marginal_hist.sv
module marginal_hist
  import mhu_pkg::*;
#(
  parameter int NQ     = 4,
  parameter int AW     = 8,
  parameter int RW     = 16,
  parameter int GUARD  = 8,
  parameter int CUTOFF = 4,
  localparam int NB    = 1 << NQ,
  localparam int PW    = 2 * AW,
  localparam int ACC_W = PW + GUARD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             amp_valid,
  output logic             amp_ready,
  input  logic [NQ-1:0]    amp_index,
  input  logic [AW-1:0]    amp_re,
  input  logic [AW-1:0]    amp_im,
  input  logic             amp_last,
  input  logic [NQ-1:0]    meas_mask,
  input  logic             samp_valid,
  output logic             samp_ready,
  input  logic [RW-1:0]    samp_rand,
  output logic             res_valid,
  output logic [NQ-1:0]    res_bin,
  input  logic [NQ-1:0]    hist_addr,
  output logic [ACC_W-1:0] hist_data
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  mhu_state_e       state_q, state_d;
  logic             fresh_q, fresh_d;
  logic [NQ-1:0]    mask_q, mask_d;
  logic [NQ-1:0]    ptr_q, ptr_d;
  logic [ACC_W-1:0] bin_q [NB];
  logic [ACC_W-1:0] bin_d [NB];
  logic [ACC_W-1:0] cum_q [NB];
  logic [ACC_W-1:0] cum_d [NB];
  logic             res_valid_q, res_valid_d;
  logic [NQ-1:0]    res_bin_q, res_bin_d;

  logic             amp_fire, samp_fire;
  logic [NQ-1:0]    eff_mask, wr_addr, last_bin, pick;
  logic [PW-1:0]    prob;
  logic [ACC_W-1:0] scan_prev;

  function automatic logic [ACC_W-1:0] sat_add(input logic [ACC_W-1:0] a,
                                               input logic [ACC_W-1:0] b);
    logic [ACC_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[ACC_W] ? '1 : s[ACC_W-1:0];
  endfunction

  assign amp_ready  = (state_q != ST_SCAN);
  assign samp_ready = (state_q == ST_DRAW);
  assign amp_fire   = amp_valid & amp_ready;
  assign samp_fire  = samp_valid & samp_ready;
  assign eff_mask   = fresh_q ? meas_mask : mask_q;
  assign last_bin   = NQ'((1 << $countones(mask_q)) - 1);
  assign scan_prev  = (ptr_q == '0) ? '0 : cum_q[ptr_q - 1'b1];
  assign hist_data  = bin_q[hist_addr];
  assign res_valid  = res_valid_q;
  assign res_bin    = res_bin_q;

  mhu_prob #(.AW(AW), .CUTOFF(CUTOFF)) u_prob (
    .re(amp_re), .im(amp_im), .prob(prob)
  );

  mhu_bin_pack #(.NQ(NQ)) u_pack (
    .idx(amp_index), .mask(eff_mask), .addr(wr_addr)
  );

  mhu_draw #(.NQ(NQ), .ACC_W(ACC_W), .RW(RW)) u_draw (
    .cum(cum_q), .last_bin(last_bin), .rnd(samp_rand), .pick(pick)
  );

  always_comb begin
    state_d     = state_q;
    fresh_d     = fresh_q;
    mask_d      = mask_q;
    ptr_d       = ptr_q;
    bin_d       = bin_q;
    cum_d       = cum_q;
    res_valid_d = samp_fire;
    res_bin_d   = samp_fire ? pick : res_bin_q;
    unique case (state_q)
      ST_GATHER, ST_DRAW: begin
        if (amp_fire) begin
          if (fresh_q) begin
            for (int b = 0; b < NB; b++) bin_d[b] = '0;
            mask_d = meas_mask;
          end
          bin_d[wr_addr] = sat_add(fresh_q ? '0 : bin_q[wr_addr], ACC_W'(prob));
          fresh_d = amp_last;
          ptr_d   = '0;
          state_d = amp_last ? ST_SCAN : ST_GATHER;
        end
      end
      ST_SCAN: begin
        cum_d[ptr_q] = sat_add(scan_prev, bin_q[ptr_q]);
        ptr_d        = ptr_q + 1'b1;
        if (ptr_q == NQ'(NB - 1)) state_d = ST_DRAW;
      end
      default: state_d = ST_GATHER;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q     <= ST_GATHER;
      fresh_q     <= 1'b1;
      mask_q      <= '0;
      ptr_q       <= '0;
      res_valid_q <= 1'b0;
      res_bin_q   <= '0;
      for (int b = 0; b < NB; b++) begin
        bin_q[b] <= '0;
        cum_q[b] <= '0;
      end
    end else begin
      state_q     <= state_d;
      fresh_q     <= fresh_d;
      mask_q      <= mask_d;
      ptr_q       <= ptr_d;
      res_valid_q <= res_valid_d;
      res_bin_q   <= res_bin_d;
      for (int b = 0; b < NB; b++) begin
        bin_q[b] <= bin_d[b];
        cum_q[b] <= cum_d[b];
      end
    end
  end
endmodule

// File: rtl/mhu_checker.sv
module mhu_checker #(
  parameter int NQ = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          amp_valid,
  input logic          amp_ready,
  input logic          amp_last,
  input logic          samp_valid,
  input logic          samp_ready,
  input logic          res_valid,
  input logic [NQ-1:0] res_bin,
  input logic [NQ-1:0] last_bin
);
  // R7: the scan follows the last beat, so no sample is taken right after it
  assert_scan_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (amp_valid && amp_ready && amp_last) |=> !samp_ready);

  // R7: sampling opens only after a cycle in which beats were refused
  assert_draw_after_scan_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(samp_ready) |-> $past(!amp_ready));

  // R8: every accepted request is answered on the next cycle
  assert_result_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_valid && samp_ready) |=> res_valid);

  // R8: no result without an accepted request one cycle earlier
  assert_no_spurious_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(samp_valid && samp_ready));

  // R9: an outcome never lies beyond the highest active bin
  assert_outcome_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_bin <= $past(last_bin)));
endmodule

bind marginal_hist mhu_checker #(.NQ(NQ)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .amp_valid  (amp_valid),
  .amp_ready  (amp_ready),
  .amp_last   (amp_last),
  .samp_valid (samp_valid),
  .samp_ready (samp_ready),
  .res_valid  (res_valid),
  .res_bin    (res_bin),
  .last_bin   (last_bin)
);

// File: tb/marginal_hist_tb.sv
module marginal_hist_tb;
  localparam int NQ = 4;
  localparam int AW = 8;
  localparam int RW = 16;
  localparam int NB = 1 << NQ;
  localparam int ACC_W = 2 * AW + 8;
  localparam int CUT = 4;

  logic             clk;
  logic             rst_n;
  logic             amp_valid, amp_ready, amp_last;
  logic [NQ-1:0]    amp_index, meas_mask;
  logic [AW-1:0]    amp_re, amp_im;
  logic             samp_valid, samp_ready;
  logic [RW-1:0]    samp_rand;
  logic             res_valid;
  logic [NQ-1:0]    res_bin, hist_addr;
  logic [ACC_W-1:0] hist_data;

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  int re_v[NB];
  int im_v[NB];
  longint mdl_hist[NB];
  int mdl_n;
  bit done = 0;

  marginal_hist u_dut (
    .clk(clk), .rst_n(rst_n),
    .amp_valid(amp_valid), .amp_ready(amp_ready), .amp_index(amp_index),
    .amp_re(amp_re), .amp_im(amp_im), .amp_last(amp_last), .meas_mask(meas_mask),
    .samp_valid(samp_valid), .samp_ready(samp_ready), .samp_rand(samp_rand),
    .res_valid(res_valid), .res_bin(res_bin),
    .hist_addr(hist_addr), .hist_data(hist_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // model of the histogram for the current amplitude set and mask
  task automatic build_model(input logic [NQ-1:0] mask);
    mdl_n = 1 << $countones(mask);
    for (int b = 0; b < NB; b++) mdl_hist[b] = 0;
    for (int k = 0; k < NB; k++) begin
      longint p;
      int a, j;
      p = longint'(re_v[k] * re_v[k] + im_v[k] * im_v[k]);
      if (p < CUT) p = 0;
      a = 0; j = 0;
      for (int q = 0; q < NQ; q++)
        if (mask[q]) begin a = a | (((k >> q) & 1) << j); j++; end
      mdl_hist[a] += p;
    end
  endtask

  function automatic int predict(input int r);
    longint tot, tgt, c;
    tot = 0;
    for (int b = 0; b < mdl_n; b++) tot += mdl_hist[b];
    tgt = (longint'(r) * tot) >> RW;
    c = 0;
    for (int b = 0; b < mdl_n; b++) begin
      c += mdl_hist[b];
      if (c > tgt) return b;
    end
    return mdl_n - 1;
  endfunction

  // driver: one full pass, starting at a negative edge
  task automatic send_pass(input logic [NQ-1:0] mask);
    for (int k = 0; k < NB; k++) begin
      amp_valid = 1'b1;
      amp_index = NQ'(k);
      amp_re    = AW'(re_v[k]);
      amp_im    = AW'(im_v[k]);
      amp_last  = (k == NB - 1);
      meas_mask = mask;
      while (!amp_ready) @(negedge clk);
      @(negedge clk);
    end
    amp_valid = 1'b0;
    amp_last  = 1'b0;
  endtask

  // driver: one sample request; the expected outcome goes to the scoreboard
  task automatic do_sample(input int r, input string req);
    samp_valid = 1'b1;
    samp_rand  = RW'(r);
    while (!samp_ready) @(negedge clk);
    exp_q.push_back(predict(r));
    @(negedge clk);
    samp_valid = 1'b0;
    check(res_valid == 1'b1, req, longint'(res_valid), 1);
  endtask

  task automatic wait_draw();
    while (!samp_ready) @(negedge clk);
  endtask

  task automatic check_hist(input string req);
    for (int b = 0; b < NB; b++) begin
      hist_addr = NQ'(b);
      #1;
      check(longint'(hist_data) == mdl_hist[b], req, longint'(hist_data), mdl_hist[b]);
    end
  endtask

  // monitor: compares each outcome with the scoreboard head
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 R8 unexpected result", longint'(res_bin), -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        check(int'(res_bin) == e, "R8 R9 R10 outcome", longint'(res_bin), e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; amp_valid = 1'b0; amp_last = 1'b0; amp_index = '0;
    amp_re = '0; amp_im = '0; meas_mask = '0; samp_valid = 1'b0;
    samp_rand = '0; hist_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    check(amp_ready == 1'b1, "R7 reset amp_ready", longint'(amp_ready), 1);
    check(samp_ready == 1'b0, "R7 reset samp_ready", longint'(samp_ready), 0);
    check(res_valid == 1'b0, "R8 reset res_valid", longint'(res_valid), 0);
    #1 check(hist_data == '0, "R6 reset bin", longint'(hist_data), 0);
    @(negedge clk);

    // pass A: scattered mask {q2,q0}; request held high from before the pass
    for (int k = 0; k < NB; k++) begin
      re_v[k] = (k * 37) % 23 - 11;
      im_v[k] = (k * 11) % 17 - 8;
    end
    re_v[5] = 1;  im_v[5] = 1;   // 2, below cutoff
    re_v[12] = 0; im_v[12] = 1;  // 1, below cutoff
    build_model(4'b0101);
    samp_valid = 1'b1;
    samp_rand  = RW'(12345);
    send_pass(4'b0101);
    check(samp_ready == 1'b0, "R7 held during scan", longint'(samp_ready), 0);
    check(amp_ready == 1'b0, "R7 beats refused during scan", longint'(amp_ready), 0);
    do_sample(12345, "R7 held request served");
    check_hist("R1 R3 mask 0101");
    do_sample(0, "R8 rand zero");
    do_sample(65535, "R8 rand max");
    do_sample(30000, "R8 rand mid");

    // same cycle: sample from A while pass E begins (mask {q3,q1})
    samp_valid = 1'b1;
    samp_rand  = RW'(50000);
    check(samp_ready && amp_ready, "R10 both ready", longint'(samp_ready), 1);
    exp_q.push_back(predict(50000));
    for (int k = 0; k < NB; k++) begin
      re_v[k] = (k * 5) % 13 - 6;
      im_v[k] = 7 - (k * 3) % 9;
    end
    fork
      send_pass(4'b1010);
      begin @(negedge clk); samp_valid = 1'b0; end
    join
    build_model(4'b1010);
    wait_draw();
    check_hist("R3 R10 mask 1010 new pass");
    do_sample(40000, "R8 pass E");

    // pass B: empty mask, cutoff edges
    for (int k = 0; k < NB; k++) begin re_v[k] = 0; im_v[k] = 0; end
    re_v[7] = -3; im_v[7] = 5;   // 34
    re_v[2] = 1;  im_v[2] = 1;   // 2 dropped
    re_v[9] = 2;  im_v[9] = 0;   // 4 kept
    build_model(4'b0000);
    send_pass(4'b0000);
    wait_draw();
    hist_addr = '0; #1;
    check(hist_data == ACC_W'(38), "R2 cutoff total", longint'(hist_data), 38);
    check_hist("R4 R6 single bin, others cleared");
    do_sample(65535, "R4 empty mask");

    // pass C: all-zero state, total zero
    for (int k = 0; k < NB; k++) begin re_v[k] = 0; im_v[k] = 0; end
    build_model(4'b0011);
    send_pass(4'b0011);
    wait_draw();
    do_sample(0, "R9 zero total");
    do_sample(40000, "R9 zero total high rand");

    // pass D: largest terms into one bin
    for (int k = 0; k < NB; k++) begin re_v[k] = -128; im_v[k] = -128; end
    build_model(4'b0000);
    send_pass(4'b0000);
    wait_draw();
    hist_addr = '0; #1;
    check(hist_data == ACC_W'(524288), "R5 wide accumulator", longint'(hist_data), 524288);
    do_sample(65535, "R5 sample");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R8 scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule